// File: doc/BRIEF.md
# Banked Cartridge Memory Mapper

This block places a processor address window of two equal halves over a backing store that has four equal slices. Slices 0 to 2 are RAM and slice 3 is a fixed boot ROM. A configuration byte picks one of eight pairings of slices for the lower and upper halves. It also carries a ROM power control, a RAM write enable, and a five-bit bank identifier that can be read back. Each slice holds 2**SLICE_AW bytes. The parameter is 11 for the full 2 KB slice and defaults to 9 so that the default build stays small.

Stores never go straight to memory. A capture strobe latches a byte into a hold register and raises a pending flag. The next accepted access then commits that byte at the slice and offset it addresses. The commit is dropped if the access lands in the upper half while that half maps the ROM. Either way, the pending flag clears.

Accesses use a valid/ready handshake. Ready stays low while the ROM slice is filled after reset. Once it rises it stays high. An access that is presented while ready is low is neither accepted nor answered. Every accepted access gets a one-cycle response pulse that carries the read byte, the physical address and the write flag. The response has no back-pressure. Configuration and capture inputs are plain strobes.

Top module: `bank_mapper`

## Requirements
- R1: After reset the ROM slice (slice 3) is filled, one byte per cycle, with 0x02, except its last four offsets, which hold 0x0A, 0xF8, 0x0A, 0xF8 in rising order. While the fill runs, acc_ready is 0 and presented accesses get no response; afterwards acc_ready is 1.
- R2: Address bit SLICE_AW selects the half (0 lower, 1 upper). Bits SLICE_AW-1:0 are the offset within the slice. The physical address is {slice[1:0], offset}.
- R3: Configuration bits 4:2 pick the (lower, upper) slice pair as follows: 0:(2,3) 1:(0,3) 2:(2,0) 3:(0,2) 4:(2,3) 5:(1,3) 6:(2,1) 7:(1,2). The new pairing applies to accesses from the cycle after the configuration strobe.
- R4: bank_id equals configuration bits 4:0, and rom_powered equals the inverse of bit 0. bank_changed pulses high for exactly one cycle after each configuration strobe. After reset, bank_id is 0, rom_powered is 1 and the pairing is selection 0.
- R5: A capture strobe loads the hold register and sets pending only when configuration bit 1 is 1; otherwise it has no effect. A second capture while a byte is pending replaces the held byte.
- R6: An accepted lower-half access with a byte pending stores that byte at the lower slice and offset; the response shows mem_we 1 and returns the stored byte.
- R7: An accepted upper-half access with a byte pending stores it only if the upper slice is not 3; otherwise it is dropped, mem_we stays 0 and the ROM byte is returned.
- R8: Every accepted access clears pending, whether the byte was stored or dropped, so the following access writes nothing.
- R9: rd_valid pulses for one cycle, in the cycle after an access is accepted. With it come rd_data, mem_addr and mem_we for that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration strobe |
| cfg_byte | input | 8 | Configuration value |
| bank_id | output | 5 | Retained bank identifier |
| rom_powered | output | 1 | ROM power state |
| bank_changed | output | 1 | One-cycle pulse after a configuration strobe |
| cap_load | input | 1 | Capture strobe for the hold register |
| cap_data | input | 8 | Byte to capture |
| acc_valid | input | 1 | Access request valid |
| acc_ready | output | 1 | Access request ready |
| acc_addr | input | SLICE_AW+1 | Window address |
| rd_valid | output | 1 | Response pulse |
| rd_data | output | 8 | Read byte |
| mem_addr | output | SLICE_AW+2 | Physical address of the answered access |
| mem_we | output | 1 | The answered access committed a store |

## Verification
The assertions assume that cfg_wr, cap_load and an accepted access never arrive in the same cycle. The assertion on pending clearing and the one on bank_id stability both count on that separation. Each bench task drives one strobe per cycle and releases it at the next falling edge. The bench also holds every input low during reset, so no check sees values from before the first edge.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;
  typedef logic [1:0] slice_t;

  typedef struct packed {
    slice_t lo;
    slice_t hi;
  } pair_t;

  localparam slice_t ROM_SLICE = 2'd3;

  function automatic pair_t pair_of(input logic [2:0] sel);
    pair_t p;
    case (sel)
      3'd0: p = '{lo: 2'd2, hi: 2'd3};
      3'd1: p = '{lo: 2'd0, hi: 2'd3};
      3'd2: p = '{lo: 2'd2, hi: 2'd0};
      3'd3: p = '{lo: 2'd0, hi: 2'd2};
      3'd4: p = '{lo: 2'd2, hi: 2'd3};
      3'd5: p = '{lo: 2'd1, hi: 2'd3};
      3'd6: p = '{lo: 2'd2, hi: 2'd1};
      default: p = '{lo: 2'd1, hi: 2'd2};
    endcase
    return p;
  endfunction
endpackage

// File: rtl/bank_cfg.sv
module bank_cfg
  import bank_mapper_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_byte,
  output logic [4:0] bank_id,
  output logic       rom_powered,
  output logic       ram_wr_en,
  output logic       bank_changed,
  output pair_t      pair
);
  logic [4:0] cfg_q;
  logic       unused_cfg_hi;

  assign unused_cfg_hi = ^cfg_byte[7:5];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q        <= '0;
      bank_changed <= 1'b0;
    end else begin
      bank_changed <= cfg_wr;
      if (cfg_wr) cfg_q <= cfg_byte[4:0];
    end
  end

  assign bank_id     = cfg_q;
  assign rom_powered = ~cfg_q[0];
  assign ram_wr_en   = cfg_q[1];
  assign pair        = pair_of(cfg_q[4:2]);

  a_r4_id_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_wr) |-> $stable(bank_id));
endmodule

// File: rtl/hold_reg.sv
module hold_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          enable,
  input  logic [DW-1:0] din,
  input  logic          consume,
  output logic          pending,
  output logic [DW-1:0] held
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      held    <= '0;
    end else if (load && enable) begin
      pending <= 1'b1;
      held    <= din;
    end else if (consume) begin
      pending <= 1'b0;
    end
  end
endmodule

// File: rtl/slice_store.sv
module slice_store #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          we,
  input  logic [AW+1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          init_done
);
  localparam int SLICE_N = 1 << AW;
  localparam int DEPTH   = 4 * SLICE_N;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] fill_cnt;
  logic [DW-1:0] fill_byte;

  always_comb begin
    if (int'(fill_cnt) >= SLICE_N - 4) fill_byte = fill_cnt[0] ? DW'(8'hF8) : DW'(8'h0A);
    else                               fill_byte = DW'(8'h02);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_cnt  <= '0;
      init_done <= 1'b0;
    end else if (!init_done) begin
      fill_cnt <= fill_cnt + 1'b1;
      if (int'(fill_cnt) == SLICE_N - 1) init_done <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !init_done) mem[{2'b11, fill_cnt}] <= fill_byte;
    else if (we)             mem[addr] <= wdata;
    if (rd_en) rdata <= we ? wdata : mem[addr];
  end

  a_r7_rom_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && we) |-> (addr[AW+1:AW] != 2'b11));
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bank_mapper_pkg::*;
#(
  parameter int SLICE_AW = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [7:0]          cfg_byte,
  output logic [4:0]          bank_id,
  output logic                rom_powered,
  output logic                bank_changed,
  input  logic                cap_load,
  input  logic [7:0]          cap_data,
  input  logic                acc_valid,
  output logic                acc_ready,
  input  logic [SLICE_AW:0]   acc_addr,
  output logic                rd_valid,
  output logic [7:0]          rd_data,
  output logic [SLICE_AW+1:0] mem_addr,
  output logic                mem_we
);
  localparam int PAW = SLICE_AW + 2;

  pair_t          pair;
  logic           ram_wr_en, pending, fire, upper, commit, init_done;
  logic [7:0]     held;
  slice_t         slice;
  logic [PAW-1:0] phys;

  bank_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_byte(cfg_byte),
    .bank_id(bank_id), .rom_powered(rom_powered), .ram_wr_en(ram_wr_en),
    .bank_changed(bank_changed), .pair(pair)
  );

  hold_reg #(.DW(8)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(cap_load), .enable(ram_wr_en),
    .din(cap_data), .consume(fire), .pending(pending), .held(held)
  );

  assign acc_ready = init_done;
  assign fire      = acc_valid && acc_ready;
  assign upper     = acc_addr[SLICE_AW];
  assign slice     = upper ? pair.hi : pair.lo;
  assign phys      = {slice, acc_addr[SLICE_AW-1:0]};
  assign commit    = fire && pending && !(upper && slice == ROM_SLICE);

  slice_store #(.AW(SLICE_AW), .DW(8)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_en(fire), .we(commit), .addr(phys),
    .wdata(held), .rdata(rd_data), .init_done(init_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      mem_addr <= '0;
      mem_we   <= 1'b0;
    end else begin
      rd_valid <= fire;
      if (fire) begin
        mem_addr <= phys;
        mem_we   <= commit;
      end
    end
  end

  a_r9_resp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(acc_valid && acc_ready));
  a_r8_pending_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !cap_load) |=> !pending);
  a_r4_changed_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bank_changed |-> $past(cfg_wr));
  a_r1_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ready |=> acc_ready);
endmodule

// File: tb/bank_mapper_tb_top.sv
module bank_mapper_tb_top;
  localparam int SAW = 9;
  localparam int N   = 1 << SAW;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cfg_wr = 1'b0;
  logic [7:0]     cfg_byte = '0;
  logic [4:0]     bank_id;
  logic           rom_powered, bank_changed;
  logic           cap_load = 1'b0;
  logic [7:0]     cap_data = '0;
  logic           acc_valid = 1'b0;
  logic           acc_ready;
  logic [SAW:0]   acc_addr = '0;
  logic           rd_valid;
  logic [7:0]     rd_data;
  logic [SAW+1:0] mem_addr;
  logic           mem_we;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  bank_mapper #(.SLICE_AW(SAW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_byte(cfg_byte),
    .bank_id(bank_id), .rom_powered(rom_powered), .bank_changed(bank_changed),
    .cap_load(cap_load), .cap_data(cap_data), .acc_valid(acc_valid),
    .acc_ready(acc_ready), .acc_addr(acc_addr), .rd_valid(rd_valid),
    .rd_data(rd_data), .mem_addr(mem_addr), .mem_we(mem_we)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [7:0] v);
    @(negedge clk); cfg_wr = 1'b1; cfg_byte = v;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic cap(input logic [7:0] v);
    @(negedge clk); cap_load = 1'b1; cap_data = v;
    @(negedge clk); cap_load = 1'b0;
  endtask

  // one accepted access; response sampled at the next falling edge
  task automatic acc(input logic up, input int off,
                     output logic [7:0] d, output int pa, output logic we);
    @(negedge clk); acc_valid = 1'b1; acc_addr = {up, SAW'(off)};
    @(negedge clk); acc_valid = 1'b0;
    chk("R9 rd_valid pulse", int'(rd_valid), 1);
    d = rd_data; pa = int'(mem_addr); we = mem_we;
    @(negedge clk);
    chk("R9 rd_valid single", int'(rd_valid), 0);
  endtask

  task automatic t_reset_fill();
    int wait_cyc = 0;
    @(negedge clk);
    chk("R4 reset bank_id", int'(bank_id), 0);
    chk("R4 reset rom_powered", int'(rom_powered), 1);
    chk("R1 ready low in fill", int'(acc_ready), 0);
    acc_valid = 1'b1; acc_addr = '0;
    @(negedge clk);
    chk("R1 no response in fill", int'(rd_valid), 0);
    acc_valid = 1'b0;
    while (!acc_ready && wait_cyc < 2 * N) begin @(negedge clk); wait_cyc++; end
    chk("R1 ready after fill", int'(acc_ready), 1);
  endtask

  task automatic t_rom_content();
    logic [7:0] d; int pa; logic we;
    acc(1'b1, 0, d, pa, we);      chk("R1 rom fill byte", d, 8'h02);
    chk("R2 phys upper rom", pa, (3 << SAW));
    acc(1'b1, 100, d, pa, we);    chk("R1 rom fill byte", d, 8'h02);
    acc(1'b1, N - 4, d, pa, we);  chk("R1 vector byte 0", d, 8'h0A);
    acc(1'b1, N - 3, d, pa, we);  chk("R1 vector byte 1", d, 8'hF8);
    acc(1'b1, N - 2, d, pa, we);  chk("R1 vector byte 2", d, 8'h0A);
    acc(1'b1, N - 1, d, pa, we);  chk("R1 vector byte 3", d, 8'hF8);
    chk("R2 phys last offset", pa, (3 << SAW) | (N - 1));
  endtask

  task automatic t_cfg_fields();
    cfg(8'hFF);
    chk("R4 bank_changed pulse", int'(bank_changed), 1);
    chk("R4 bank_id low bits", int'(bank_id), 5'h1F);
    chk("R4 rom power off", int'(rom_powered), 0);
    @(negedge clk);
    chk("R4 bank_changed one cycle", int'(bank_changed), 0);
  endtask

  task automatic t_map_table();
    logic [7:0] d; int pa; logic we;
    int lo_exp [8] = '{2, 0, 2, 0, 2, 1, 2, 1};
    int hi_exp [8] = '{3, 3, 0, 2, 3, 3, 1, 2};
    for (int s = 0; s < 8; s++) begin
      cfg(8'((s << 2) | 2));
      acc(1'b0, 16, d, pa, we);
      chk("R3 lower slice", pa >> SAW, lo_exp[s]);
      chk("R2 lower offset", pa & (N - 1), 16);
      acc(1'b1, 16, d, pa, we);
      chk("R3 upper slice", pa >> SAW, hi_exp[s]);
    end
  endtask

  task automatic t_commit_lower();
    logic [7:0] d; int pa; logic we;
    cfg(8'h02);
    cap(8'h5A);
    acc(1'b0, 5, d, pa, we);
    chk("R6 lower commit we", int'(we), 1);
    chk("R6 lower commit data", d, 8'h5A);
    chk("R6 lower commit addr", pa, (2 << SAW) | 5);
    acc(1'b0, 6, d, pa, we);
    chk("R8 no second write", int'(we), 0);
    acc(1'b0, 5, d, pa, we);
    chk("R6 stored byte readback", d, 8'h5A);
  endtask

  task automatic t_drop_rom();
    logic [7:0] d; int pa; logic we;
    cap(8'h77);
    acc(1'b1, 5, d, pa, we);
    chk("R7 rom write dropped", int'(we), 0);
    chk("R7 rom byte returned", d, 8'h02);
    acc(1'b0, 5, d, pa, we);
    chk("R8 pending cleared on drop", int'(we), 0);
    chk("R7 lower unaffected", d, 8'h5A);
    acc(1'b1, 5, d, pa, we);
    chk("R7 rom still intact", d, 8'h02);
  endtask

  task automatic t_commit_upper_ram();
    logic [7:0] d; int pa; logic we;
    cfg(8'h0E);                   // selection 3: lower 0, upper 2
    cap(8'h33);
    acc(1'b1, 9, d, pa, we);
    chk("R7 upper ram commit we", int'(we), 1);
    chk("R7 upper ram addr", pa, (2 << SAW) | 9);
    cfg(8'h02);                   // selection 0: lower 2
    acc(1'b0, 9, d, pa, we);
    chk("R7 upper store seen via lower", d, 8'h33);
  endtask

  task automatic t_capture_rules();
    logic [7:0] d; int pa; logic we;
    cfg(8'h00);                   // write enable bit 1 clear
    cap(8'h99);
    cfg(8'h02);
    acc(1'b0, 5, d, pa, we);
    chk("R5 capture ignored we", int'(we), 0);
    chk("R5 capture ignored data", d, 8'h5A);
    cap(8'h11);
    cap(8'h22);
    acc(1'b0, 7, d, pa, we);
    chk("R5 overwrite data", d, 8'h22);
    acc(1'b0, 7, d, pa, we);
    chk("R5 overwrite stored", d, 8'h22);
    chk("R8 single commit", int'(we), 0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_fill();
    t_rom_content();
    t_cfg_fields();
    t_map_table();
    t_commit_lower();
    t_drop_rom();
    t_commit_upper_ram();
    t_capture_rules();
    summary();
  end
endmodule